// File: doc/BRIEF.md
# Bidirectional Shift Register with Mode Select

This block is a synchronous register of parameterised width whose action on every rising clock edge is picked by a two-bit mode code. The four codes shift the contents one place toward the least significant end, shift them one place toward the most significant end, keep them unchanged, or replace them with a parallel word. Each shift direction has its own serial input. On a right shift, the bit entering at the top comes from `ser_from_left`. On a left shift, the bit entering at the bottom comes from `ser_from_right`.

The register contents are the only output. Typical uses are serial-to-parallel conversion in either bit order, parallel-to-serial conversion by reading an end bit of `q`, and simple data alignment. A synchronous active-low reset clears the register. The width `W` must be at least 2.

Top module: `bidir_shift_reg`

## Requirements
- R1: When `rst_n` is low at a rising edge, `q` is all zeros after that edge, whatever the mode code and data inputs are.
- R2: Mode code {`mode_hi`,`mode_lo`} = 2'b00 shifts right: after the edge, `q[W-1]` equals `ser_from_left`, and `q[i]` equals the previous `q[i+1]` for every i below W-1.
- R3: Mode code 2'b01 shifts left: after the edge, `q[0]` equals `ser_from_right`, and `q[i]` equals the previous `q[i-1]` for every i above 0.
- R4: Mode code 2'b10 holds: `q` keeps its value across the edge.
- R5: Mode code 2'b11 loads: after the edge, `q` equals `par_in` as sampled at that edge.
- R6: In a right shift `ser_from_right` has no effect on `q`. In a left shift `ser_from_left` has no effect on `q`.
- R7: `par_in` has no effect on `q` in the modes 2'b00, 2'b01 and 2'b10.
- R8: `q` changes only at a rising clock edge. Input changes between edges do not show on `q`.
- R9: Successive shifts compose. W right shifts fill `q` with the serial bits, with the first bit presented ending in `q[0]`. W left shifts fill `q` with the first bit presented ending in `q[W-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_hi | input | 1 | Upper bit of the mode code |
| mode_lo | input | 1 | Lower bit of the mode code |
| ser_from_left | input | 1 | Bit entering at the MSB on a right shift |
| ser_from_right | input | 1 | Bit entering at the LSB on a left shift |
| par_in | input | W | Parallel word taken in load mode |
| q | output | W | Register contents |

## Verification
Each register bit is an output, so a wrong next-state choice for any bit appears on `q` one edge after the stimulus. A mis-decoded mode code usually corrupts several bits at once in that same cycle. A swapped neighbour connection or serial input appears only on a shift in the affected direction. Filling the register with a known serial pattern exposes such a fault within W edges, and the bench compares `q` after every edge.

// File: rtl/shreg_pkg.sv
// Package: shared types for the bidirectional shift register.
// Assumes: the mode code is the two-bit value {hi, lo}.
package shreg_pkg;

    // Mode encoding; the values are fixed by the block's interface
    typedef enum logic [1:0] {
        MODE_SHR  = 2'b00,
        MODE_SHL  = 2'b01,
        MODE_HOLD = 2'b10,
        MODE_LOAD = 2'b11
    } shmode_e;

    // Per-bit source selection; all zero means keep the current bit
    typedef struct packed {
        logic take_upper;   // bit from the more significant neighbour
        logic take_lower;   // bit from the less significant neighbour
        logic take_par;     // bit from the parallel input
    } slice_sel_t;

endpackage

// File: rtl/shreg_mode_decode.sv
// Module: shreg_mode_decode
// Turns the two-bit mode code into one-hot source selects that every bit
// slice shares. Assumes: purely combinational; hold gives an all-zero select.
module shreg_mode_decode
    import shreg_pkg::*;
(
    input  logic [1:0] code,
    output slice_sel_t sel
);

    shmode_e mode;
    assign mode = shmode_e'(code);

    // Decode the mode into one select per source
    always_comb begin
        sel = '0;
        case (mode)
            MODE_SHR:  sel.take_upper = 1'b1;
            MODE_SHL:  sel.take_lower = 1'b1;
            MODE_LOAD: sel.take_par   = 1'b1;
            default:   sel = '0;
        endcase
    end

endmodule

// File: rtl/shreg_bit_slice.sv
// Module: shreg_bit_slice
// Computes the next value of one register bit from its own value, its two
// neighbours and its parallel input bit. Assumes: at most one select is set.
module shreg_bit_slice
    import shreg_pkg::*;
(
    input  slice_sel_t sel,
    input  logic       own,
    input  logic       upper,
    input  logic       lower,
    input  logic       par,
    output logic       nxt
);

    // Pick the source for this bit
    always_comb begin
        if (sel.take_par)
            nxt = par;
        else if (sel.take_upper)
            nxt = upper;
        else if (sel.take_lower)
            nxt = lower;
        else
            nxt = own;
    end

endmodule

// File: rtl/bidir_shift_reg.sv
// Module: bidir_shift_reg
// W-bit register with four modes chosen by {mode_hi, mode_lo}: shift right,
// shift left, hold and parallel load. Synchronous active-low reset.
// Assumes: W >= 2.
module bidir_shift_reg
    import shreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_hi,
    input  logic         mode_lo,
    input  logic         ser_from_left,
    input  logic         ser_from_right,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);

    localparam int MSB = W - 1;

    slice_sel_t   sel;
    logic [W-1:0] nxt;

    shreg_mode_decode u_dec (
        .code ({mode_hi, mode_lo}),
        .sel  (sel)
    );

    // One slice per bit; the end bits take the serial inputs as neighbours
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic up_src;
        logic lo_src;
        if (i == MSB) begin : g_top
            assign up_src = ser_from_left;
        end else begin : g_mid_up
            assign up_src = q[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_src = ser_from_right;
        end else begin : g_mid_lo
            assign lo_src = q[i-1];
        end
        shreg_bit_slice u_slice (
            .sel   (sel),
            .own   (q[i]),
            .upper (up_src),
            .lower (lo_src),
            .par   (par_in[i]),
            .nxt   (nxt[i])
        );
    end

    // State register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= nxt;
    end

    // R1: reset clears the register
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    // R2: right shift
    a_r2_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_hi, mode_lo} == 2'b00)
        |=> q == {$past(ser_from_left), $past(q[MSB:1])});

    // R3: left shift
    a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_hi, mode_lo} == 2'b01)
        |=> q == {$past(q[MSB-1:0]), $past(ser_from_right)});

    // R4: hold
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_hi, mode_lo} == 2'b10) |=> $stable(q));

    // R5: load
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_hi, mode_lo} == 2'b11) |=> q == $past(par_in));

endmodule

// File: tb/tb_bidir_shift_reg.sv
// Directed bench for bidir_shift_reg.
module tb_bidir_shift_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_hi = 1'b0;
    logic         mode_lo = 1'b0;
    logic         ser_from_left = 1'b0;
    logic         ser_from_right = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;

    int total = 0;
    int bad = 0;

    bidir_shift_reg #(.W(W)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_hi        (mode_hi),
        .mode_lo        (mode_lo),
        .ser_from_left  (ser_from_left),
        .ser_from_right (ser_from_right),
        .par_in         (par_in),
        .q              (q)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] exp);
        total++;
        if (q !== exp) begin
            bad++;
            $display("FAIL %s: q=%h expected=%h", req, q, exp);
        end
    endtask

    // Drive inputs at the falling edge, pass one rising edge, sample at the next falling edge
    task automatic step(input logic [1:0] m, input logic sl, input logic sr,
                        input logic [W-1:0] p);
        {mode_hi, mode_lo} = m;
        ser_from_left  = sl;
        ser_from_right = sr;
        par_in         = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(2'b11, 1'b1, 1'b1, 8'hFF);
        check("R1 reset under load", '0);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        step(2'b11, 1'b0, 1'b0, 8'hA5);
        check("R5 load A5", 8'hA5);
        step(2'b11, 1'b1, 1'b1, 8'h3C);
        check("R5 load 3C", 8'h3C);
    endtask

    task automatic t_shift_right();
        step(2'b11, 1'b0, 1'b0, 8'h96);
        step(2'b00, 1'b1, 1'b0, 8'hFF);
        check("R2 shr in 1", 8'hCB);
        step(2'b00, 1'b0, 1'b1, 8'h00);
        check("R2/R6 shr in 0, right serial ignored", 8'h65);
    endtask

    task automatic t_shift_left();
        step(2'b11, 1'b0, 1'b0, 8'h96);
        step(2'b01, 1'b0, 1'b1, 8'h00);
        check("R3 shl in 1", 8'h2D);
        step(2'b01, 1'b1, 1'b0, 8'hFF);
        check("R3/R6 shl in 0, left serial ignored", 8'h5A);
    endtask

    task automatic t_hold();
        step(2'b11, 1'b0, 1'b0, 8'h81);
        step(2'b10, 1'b1, 1'b1, 8'h7E);
        check("R4/R7 hold ignores par_in", 8'h81);
        step(2'b10, 1'b0, 1'b0, 8'h00);
        check("R4 hold second cycle", 8'h81);
    endtask

    task automatic t_between_edges();
        step(2'b11, 1'b0, 1'b0, 8'h11);
        {mode_hi, mode_lo} = 2'b11;
        par_in = 8'hEE;
        #1.0;
        check("R8 no change before edge", 8'h11);
        @(posedge clk);
        @(negedge clk);
        check("R8 update at edge", 8'hEE);
    endtask

    task automatic t_fill();
        logic [W-1:0] pat = 8'b1011_0010;
        step(2'b11, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < W; i++) step(2'b00, pat[i], 1'b0, 8'hFF);
        check("R9/R7 right fill", pat);
        step(2'b11, 1'b0, 1'b0, 8'hFF);
        for (int i = 0; i < W; i++) step(2'b01, 1'b1, pat[W-1-i], 8'h00);
        check("R9/R7 left fill", pat);
    endtask

    task automatic t_reset_priority();
        step(2'b11, 1'b0, 1'b0, 8'hC3);
        rst_n = 1'b0;
        step(2'b00, 1'b1, 1'b1, 8'hFF);
        check("R1 reset over shift", '0);
        rst_n = 1'b1;
        step(2'b01, 1'b0, 1'b1, 8'h00);
        check("R3 shift after reset", 8'h01);
    endtask

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: q=%h expected=finish", q);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_shift_right();
        t_shift_left();
        t_hold();
        t_between_edges();
        t_fill();
        t_reset_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule